// File: doc/BRIEF.md
# Chassis Fan Speed Controller

This block drives the supply voltage of a chassis cooling fan from a measured air temperature and reports how fast the fan is turning. A temperature sample, in tenths of a degree Fahrenheit, arrives with a one-cycle valid strobe. The block turns it into a voltage command code for an external regulator. The code is expressed in tenths of a volt and spans 5.0 V to 13.0 V. It sits at the floor when the air is cool, sits at the ceiling when the air is hot, and rises linearly between the two thresholds.

There is no tachometer wire. The fan's speed is recovered from the current pulses that its commutation produces. A digitized comparator output of the fan current passes through a synchronizer and a glitch filter. Each clean rising edge is then counted over a fixed gate window, one second at the default clock. At the end of each window the count becomes revolutions per minute. A stall flag is raised when a window sees no pulses at all while the fan is being driven above its minimum voltage.

Top module: `fan_speed_ctrl`

## Requirements
- R1: While reset is held, the voltage code is 130 (13.0 V, full cooling), the RPM output is 0 and the stall flag is 0.
- R2: A valid temperature of 900 (90.0 °F) or less sets the code to 50 (5.0 V). A valid temperature of 1050 (105.0 °F) or more sets the code to 130.
- R3: A valid temperature T strictly between 900 and 1050 sets the code to 50 + floor((T − 900) × 80 / 150). Examples: 901 gives 50, 902 gives 51, 975 gives 90 and 1049 gives 129.
- R4: The code changes only on the clock edge after a cycle with the valid strobe high. Temperature changes without the strobe have no effect on the code.
- R5: A high or low level on the fan-pulse input must last at least FILT_LEN clock cycles to be accepted. Shorter glitches are not counted. Each accepted low-to-high transition counts as exactly one pulse.
- R6: The RPM output is updated once per gate window of GATE_CYCLES cycles, with the value pulses × 60 / PULSES_PER_REV using integer division. It holds its value between window ends.
- R7: The per-window pulse count saturates at 2^CNT_W − 1 and never wraps.
- R8: At each window end the stall flag is set if the window counted zero pulses and the current code is above 50. Otherwise the flag is cleared at that window end. The flag holds its value between window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_i | input | TEMP_W | Chassis temperature, unsigned tenths of °F |
| temp_valid_i | input | 1 | One-cycle strobe marking temp_i as a new sample |
| fan_pulse_i | input | 1 | Digitized fan-current pulse signal, asynchronous |
| volt_code_o | output | CODE_W | Fan supply command in tenths of a volt (50 to 130) |
| rpm_o | output | RPM_W | Measured fan speed of the last complete window |
| stall_o | output | 1 | Fan driven above minimum but no pulses in the last window |

## Verification
A wrong voltage-mapping state shows on volt_code_o one edge after the strobe, so the per-clock comparison exposes it within one cycle. Faults in the synchronizer, glitch filter, edge counter or gate timer stay hidden inside the window. They appear only at the next window end, as a wrong rpm_o or stall_o value, or as an update on the wrong cycle. The reference model therefore places pulses and glitches well inside each window and compares on every clock. A gate counter that is off by one cycle is caught at the boundary edge itself.

// File: rtl/fan_ctrl_pkg.sv
// Shared types for the fan speed controller.
// Assumes: no parameters; included first in compile order.
package fan_ctrl_pkg;

    // Which part of the temperature-to-voltage curve a sample falls in.
    typedef enum logic [1:0] {
        BAND_COOL = 2'd0,
        BAND_RAMP = 2'd1,
        BAND_HOT  = 2'd2
    } temp_band_e;

endpackage

// File: rtl/fan_volt_map.sv
// Maps a temperature sample (tenths of °F) to a fan voltage code (tenths of V).
// Clamped at CODE_MIN below T_LO and at CODE_MAX above T_HI, linear in between.
// Assumes: T_HI > T_LO, CODE_MAX > CODE_MIN, and the code registers only on the strobe.
module fan_volt_map
    import fan_ctrl_pkg::*;
#(
    parameter int TEMP_W   = 12,
    parameter int CODE_W   = 8,
    parameter int T_LO     = 900,
    parameter int T_HI     = 1050,
    parameter int CODE_MIN = 50,
    parameter int CODE_MAX = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    output logic [CODE_W-1:0] code_o
);

    localparam int T_SPAN = T_HI - T_LO;
    localparam int C_SPAN = CODE_MAX - CODE_MIN;
    localparam int PROD_W = TEMP_W + CODE_W;

    temp_band_e        band;
    logic [TEMP_W-1:0] offset;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] code_q;

    // Classify the incoming sample against the two thresholds.
    always_comb begin
        if (temp_i <= TEMP_W'(T_LO))      band = BAND_COOL;
        else if (temp_i >= TEMP_W'(T_HI)) band = BAND_HOT;
        else                              band = BAND_RAMP;
    end

    // Linear interpolation inside the ramp band, clamped outside it.
    always_comb begin
        offset = temp_i - TEMP_W'(T_LO);
        prod   = PROD_W'(offset) * PROD_W'(C_SPAN);
        quot   = prod / PROD_W'(T_SPAN);
        case (band)
            BAND_COOL: code_d = CODE_W'(CODE_MIN);
            BAND_HOT:  code_d = CODE_W'(CODE_MAX);
            default:   code_d = CODE_W'(CODE_MIN) + CODE_W'(quot);
        endcase
    end

    // Hold the command; reset to full cooling, update only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)            code_q <= CODE_W'(CODE_MAX);
        else if (temp_valid_i) code_q <= code_d;
    end

    assign code_o = code_q;

    // R2: the command never leaves the programmed voltage span
    a_r2_code_window: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o >= CODE_W'(CODE_MIN)) && (code_o <= CODE_W'(CODE_MAX)));

    // R2: a hot sample drives the code to the ceiling on the next edge
    a_r2_hot_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid_i && temp_i >= TEMP_W'(T_HI)) |=> (code_o == CODE_W'(CODE_MAX)));

    // R4: without a strobe the command does not move
    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid_i |=> $stable(code_o));

endmodule

// File: rtl/fan_pulse_cond.sv
// Conditions the asynchronous fan-current pulse signal: a synchronizer chain,
// a persistence filter, then a one-cycle strobe on each accepted rising edge.
// Assumes: SYNC_STAGES >= 1 and FILT_LEN >= 2.
module fan_pulse_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic rise_o
);

    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   filt_q;
    logic                   prev_q;
    logic [RUN_W-1:0]       run_q;

    // Synchronizer chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= pulse_i;
            end
        end else begin : g_next
            // Later stages follow the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // Accept a new level only after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
        end else if (synced == filt_q) begin
            run_q  <= '0;
        end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
            filt_q <= synced;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    // Delay the filtered level by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= filt_q;
    end

    assign rise_o = filt_q & ~prev_q;

    // R5: an accepted edge is a single-cycle strobe
    a_r5_edge_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    // R5: the filtered level only rises when the synchronized input is high
    a_r5_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_q) |-> $past(synced));

endmodule

// File: rtl/fan_speed_meter.sv
// Counts conditioned pulse edges over a fixed gate window, converts the count
// to RPM at each window end and flags a stall.
// Assumes: GATE_CYCLES >= 2 and RPM_W >= CNT_W + 6.
module fan_speed_meter #(
    parameter int GATE_CYCLES    = 32_000_000,
    parameter int CNT_W          = 10,
    parameter int RPM_W          = 16,
    parameter int PULSES_PER_REV = 2,
    parameter int CODE_W         = 8,
    parameter int CODE_MIN       = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [RPM_W-1:0]  rpm_o,
    output logic              stall_o
);

    localparam int                 GATE_W  = $clog2(GATE_CYCLES);
    localparam int                 SCALE_W = CNT_W + 6;
    localparam logic [CNT_W-1:0]   CNT_MAX = '1;

    logic [GATE_W-1:0]  gate_q;
    logic               gate_end;
    logic [CNT_W-1:0]   win_q;
    logic [CNT_W-1:0]   cnt_next;
    logic [SCALE_W-1:0] scaled;
    logic [SCALE_W-1:0] rpm_calc;
    logic [RPM_W-1:0]   rpm_q;
    logic               stall_q;

    assign gate_end = (gate_q == GATE_W'(GATE_CYCLES - 1));

    // Free-running gate timer that wraps once per window.
    always_ff @(posedge clk) begin
        if (!rst_n)        gate_q <= '0;
        else if (gate_end) gate_q <= '0;
        else               gate_q <= gate_q + 1'b1;
    end

    // Saturating count including any edge in the current cycle.
    always_comb begin
        if (rise_i && (win_q != CNT_MAX)) cnt_next = win_q + 1'b1;
        else                              cnt_next = win_q;
    end

    // Convert a window count to revolutions per minute.
    always_comb begin
        scaled   = SCALE_W'(cnt_next) * SCALE_W'(60);
        rpm_calc = scaled / SCALE_W'(PULSES_PER_REV);
    end

    // Per-window edge accumulator, cleared at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_q <= '0;
        else if (gate_end) win_q <= '0;
        else               win_q <= cnt_next;
    end

    // Publish speed and stall once per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpm_q   <= '0;
            stall_q <= 1'b0;
        end else if (gate_end) begin
            rpm_q   <= RPM_W'(rpm_calc);
            stall_q <= (cnt_next == '0) && (code_i > CODE_W'(CODE_MIN));
        end
    end

    assign rpm_o   = rpm_q;
    assign stall_o = stall_q;

    // R6: speed only changes at a window boundary
    a_r6_rpm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> $stable(rpm_o));

    // R7: a full accumulator does not wrap inside a window
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == CNT_MAX && !gate_end) |=> (win_q == CNT_MAX));

    // R8: a stalled fan reports zero speed
    a_r8_stall_zero_rpm: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (rpm_o == '0));

    // R8: the stall flag only changes at a window boundary
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> $stable(stall_o));

endmodule

// File: rtl/fan_speed_ctrl.sv
// Top level of the chassis fan controller: temperature-to-voltage mapping plus
// speed measurement from fan-current pulses, with stall detection.
// Assumes: one clock domain; fan_pulse_i may be asynchronous to clk.
module fan_speed_ctrl #(
    parameter int TEMP_W         = 12,
    parameter int CODE_W         = 8,
    parameter int T_LO           = 900,
    parameter int T_HI           = 1050,
    parameter int CODE_MIN       = 50,
    parameter int CODE_MAX       = 130,
    parameter int SYNC_STAGES    = 2,
    parameter int FILT_LEN       = 4,
    parameter int GATE_CYCLES    = 32_000_000,
    parameter int CNT_W          = 10,
    parameter int PULSES_PER_REV = 2,
    parameter int RPM_W          = CNT_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    input  logic              fan_pulse_i,
    output logic [CODE_W-1:0] volt_code_o,
    output logic [RPM_W-1:0]  rpm_o,
    output logic              stall_o
);

    logic [CODE_W-1:0] code_w;
    logic              rise_w;

    fan_volt_map #(
        .TEMP_W   (TEMP_W),
        .CODE_W   (CODE_W),
        .T_LO     (T_LO),
        .T_HI     (T_HI),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX)
    ) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_i       (temp_i),
        .temp_valid_i (temp_valid_i),
        .code_o       (code_w)
    );

    fan_pulse_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (fan_pulse_i),
        .rise_o  (rise_w)
    );

    fan_speed_meter #(
        .GATE_CYCLES    (GATE_CYCLES),
        .CNT_W          (CNT_W),
        .RPM_W          (RPM_W),
        .PULSES_PER_REV (PULSES_PER_REV),
        .CODE_W         (CODE_W),
        .CODE_MIN       (CODE_MIN)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .code_i  (code_w),
        .rpm_o   (rpm_o),
        .stall_o (stall_o)
    );

    assign volt_code_o = code_w;

endmodule

// File: tb/sim_fan_speed_ctrl.sv
// Reference-model bench: a behavioural model of code, rpm and stall, compared
// against the design on every falling clock edge.
module sim_fan_speed_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int GATE       = 600;
    localparam int CNT_W      = 5;
    localparam int PPR        = 2;
    localparam int FILT       = 4;
    localparam int RPM_W      = CNT_W + 6;
    localparam int SAT        = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       temp = '0;
    logic              temp_valid = 1'b0;
    logic              fan_pulse = 1'b0;
    logic [7:0]        volt_code;
    logic [RPM_W-1:0]  rpm;
    logic              stall;

    fan_speed_ctrl #(
        .FILT_LEN       (FILT),
        .GATE_CYCLES    (GATE),
        .CNT_W          (CNT_W),
        .PULSES_PER_REV (PPR)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_i       (temp),
        .temp_valid_i (temp_valid),
        .fan_pulse_i  (fan_pulse),
        .volt_code_o  (volt_code),
        .rpm_o        (rpm),
        .stall_o      (stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    k = 0;
    int    n_win = 0;
    int    exp_code = 130;
    int    exp_rpm = 0;
    bit    exp_stall = 1'b0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    int    cnt_q[$];

    // Voltage curve written from the requirement text (R2, R3).
    function automatic int ref_code(input int t);
        if (t <= 900)  return 50;
        if (t >= 1050) return 130;
        return 50 + ((t - 900) * 80) / 150;
    endfunction

    // Pin level at window offset i: clean pulses first, then short glitches (R5).
    function automatic bit pin_at(input int i, input int np, input int ng);
        int gs;
        gs = 20 + 10 * np;
        if (i >= 10 && i < 10 + 10 * np) return ((i - 10) % 10) < 5;
        if (i >= gs && i < gs + 10 * ng)  return ((i - gs) % 10) < 2;
        return 1'b0;
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; exp_code = 130; exp_rpm = 0; exp_stall = 1'b0; started = 1'b1;
        end else begin
            k = k + 1;
            if (k % GATE == 0) begin
                n_win = (cnt_q.size() > 0) ? cnt_q.pop_front() : 0;
                if (n_win > SAT) n_win = SAT;                 // R7 saturation
                exp_rpm   = (n_win * 60) / PPR;               // R6
                exp_stall = (n_win == 0) && (exp_code > 50);  // R8
            end
            if (temp_valid) exp_code = ref_code(int'(temp)); // R4
        end
    end

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit bad;
            bad = 1'b0;
            vectors++;
            if (int'(volt_code) != exp_code) begin
                bad = 1'b1;
                $display("FAIL %s volt_code actual=%0d expected=%0d (k=%0d)", tag, volt_code, exp_code, k);
            end
            if (int'(rpm) != exp_rpm) begin
                bad = 1'b1;
                $display("FAIL %s rpm actual=%0d expected=%0d (k=%0d)", tag, rpm, exp_rpm, k);
            end
            if (stall != exp_stall) begin
                bad = 1'b1;
                $display("FAIL %s stall actual=%0d expected=%0d (k=%0d)", tag, stall, exp_stall, k);
            end
            if (bad) miscompares++;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // One gate window of stimulus: optional strobe, np clean pulses, ng glitches.
    task automatic run_window(input int t, input bit v, input int np, input int ng, input string req);
        tag = req;
        cnt_q.push_back(np);
        for (int i = 0; i < GATE; i++) begin
            @(negedge clk);
            temp_valid = (i == 0) && v;
            if (i == 0) temp = 12'(t);
            fan_pulse = pin_at(i, np, ng);
        end
    endtask

    initial begin
        tag = "R1";                                     // reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_window(800,  1'b1, 0,  0, "R2 R8");         // cool, no pulses, at floor: no stall
        run_window(1100, 1'b1, 7,  0, "R2 R6");         // hot clamp, 7 pulses -> 210
        run_window(975,  1'b1, 0,  0, "R3 R8");         // mid ramp 90, no pulses: stall
        run_window(901,  1'b1, 3,  5, "R3 R5");         // 50, glitches ignored -> 90
        run_window(1049, 1'b1, 40, 0, "R3 R7");         // 129, count saturates at 31 -> 930
        run_window(800,  1'b0, 1,  0, "R4 R6");         // no strobe: code stays 129
        run_window(902,  1'b1, 0,  0, "R3 R8");         // 51 just above floor: stall
        run_window(900,  1'b1, 0,  0, "R2 R8");         // exactly at threshold: no stall
        run_window(1050, 1'b1, 20, 0, "R2 R6");         // ceiling, 20 pulses -> 600
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog run incomplete actual=running expected=finished");
            finish_run();
        end
    end

endmodule